// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block measures the symbols of an already demodulated remote-control input (infrared or UHF). The input is synchronized, optionally inverted, and sampled on a tick. The tick comes from dividing the system clock by a programmable value, so that one count is meant to be 100 ns. For each symbol the block records two durations in ticks. One is how long the carrier was present (the mark). The other is the whole symbol period, from the start of one mark to the start of the next. Each (mark, period) pair goes into an eight-entry FIFO. Software computes the space as period minus mark.

When a space outlasts a programmable limit, the block pushes the pending pair with an all-ones period. This flags the end of a symbol train. The block then waits for the next mark before it measures again. Software reads the FIFO and the control and status words through a simple register bus with a combinational read path. It reads the period word first, because reading the mark word pops the entry. Interrupt status bits are sticky, are cleared by writing ones, and are masked into a single interrupt line.

Top module: `ir_capture_rx`

## Requirements
- R1: The sample tick fires once every N system clocks, where N is the divisor register at 0x64 (a value of 0 acts as 1). All durations are counted in ticks. After reset the divisor reads 1.
- R2: When bit 0 of the polarity register at 0x68 is 1, a low input level counts as carrier. When it is 0, a high level does.
- R3: For every symbol followed by another mark, the block pushes a pair whose mark is the number of carrier ticks and whose period is the carrier ticks plus the following non-carrier ticks. Both counts saturate at 0xFFFF.
- R4: If the period of a symbol reaches the maximum-period register at 0x54 while its space is still running, the block pushes the pair with period 0xFFFF. It then produces no further pair until a new mark begins.
- R5: No pair covers the idle time before the first mark. While bit 0 of the enable register at 0x50 is 0, input activity is ignored and nothing is pushed.
- R6: The FIFO holds 8 pairs. A read of 0x44 returns the oldest period and a read of 0x40 returns the oldest mark and pops it. Both read 0 when the FIFO is empty.
- R7: A pair produced while the FIFO is full is dropped and sets the overrun status. The overrun status stays set until cleared.
- R8: The interrupt status register at 0x4C has sticky bits: bit 0 is set on every accepted push, bit 1 on a push whose period is 0xFFFF, bit 2 on overrun, and bit 3 when a push fills the FIFO. Writing ones to 0x58 clears the matching bits.
- R9: The output irq is high exactly when a status bit and the matching bit of the interrupt enable register at 0x48 are both 1.
- R10: The receive status register at 0x6C holds the FIFO entry count in bits 15:8 and the overrun status in bit 2. All other bits are 0.
- R11: After reset the FIFO is empty, all status bits and enables are 0, the polarity bit is 0 and the maximum period reads 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver input (asynchronous) |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Masked interrupt request |

## Verification
The capture is tried with trains of unequal marks and spaces, which separate a swapped or off-by-one mark count from the period count. The trains begin after a long idle, which shows that no pair is made for idle time. An inverted-polarity train with an idle-high input shows that inversion is applied before measuring. A train at divisor 4 with durations that are multiples of four clocks tells tick counting apart from clock counting. A burst of ten short symbols against the eight-entry FIFO separates dropping from overwriting and shows that the overrun bit is sticky. Trailing long gaps exercise the all-ones period and the interrupt mask.

// File: rtl/ir_capture_pkg.sv
package ir_capture_pkg;
  localparam int unsigned DUR_W = 16;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  typedef enum logic [1:0] {MS_IDLE, MS_MARK, MS_SPACE} meter_state_e;

  typedef struct packed {
    logic [DUR_W-1:0] mark;
    logic [DUR_W-1:0] period;
  } ir_pair_t;

  localparam logic [7:0] A_MARK   = 8'h40;
  localparam logic [7:0] A_PERIOD = 8'h44;
  localparam logic [7:0] A_IEN    = 8'h48;
  localparam logic [7:0] A_ISTS   = 8'h4C;
  localparam logic [7:0] A_ENABLE = 8'h50;
  localparam logic [7:0] A_MAXPER = 8'h54;
  localparam logic [7:0] A_ICLR   = 8'h58;
  localparam logic [7:0] A_DIV    = 8'h64;
  localparam logic [7:0] A_POL    = 8'h68;
  localparam logic [7:0] A_RXSTAT = 8'h6C;

  localparam int unsigned IB_DATA = 0;
  localparam int unsigned IB_LAST = 1;
  localparam int unsigned IB_OVR  = 2;
  localparam int unsigned IB_FULL = 3;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = (div == '0) ? DIV_W'(1) : div;
    tick  = run && (cnt_q >= limit - DIV_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ir_symbol_meter.sv
module ir_symbol_meter
  import ir_capture_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             level,
  input  logic [DUR_W-1:0] max_per,
  output logic             push,
  output ir_pair_t         pair
);
  meter_state_e     state_q, state_d;
  logic [DUR_W-1:0] mark_q, mark_d, per_q, per_d;

  function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
    return (v == DUR_MAX) ? v : v + DUR_W'(1);
  endfunction

  always_comb begin
    state_d = state_q;
    mark_d  = mark_q;
    per_d   = per_q;
    push    = 1'b0;
    pair    = '0;
    if (!run) begin
      state_d = MS_IDLE;
      mark_d  = '0;
      per_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        MS_IDLE: if (level) begin
          state_d = MS_MARK;
          mark_d  = DUR_W'(1);
          per_d   = DUR_W'(1);
        end
        MS_MARK: begin
          per_d = sat_inc(per_q);
          if (level) mark_d  = sat_inc(mark_q);
          else       state_d = MS_SPACE;
        end
        MS_SPACE: begin
          if (level) begin
            push    = 1'b1;
            pair    = '{mark: mark_q, period: per_q};
            state_d = MS_MARK;
            mark_d  = DUR_W'(1);
            per_d   = DUR_W'(1);
          end else if (per_q >= max_per) begin
            push    = 1'b1;
            pair    = '{mark: mark_q, period: DUR_MAX};
            state_d = MS_IDLE;
          end else begin
            per_d = sat_inc(per_q);
          end
        end
        default: state_d = MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      mark_q  <= '0;
      per_q   <= '0;
    end else begin
      state_q <= state_d;
      mark_q  <= mark_d;
      per_q   <= per_d;
    end
  end
endmodule

// File: rtl/ir_pair_fifo.sv
module ir_pair_fifo
  import ir_capture_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  ir_pair_t         push_data,
  input  logic             pop,
  output ir_pair_t         head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  ir_pair_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_en, rd_en;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    full  = (cnt_q == CNT_W'(DEPTH));
    empty = (cnt_q == '0);
    wr_en = push && !full;
    rd_en = pop && !empty;
    wr_d  = wr_en ? nxt(wr_q) : wr_q;
    rd_d  = rd_en ? nxt(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
    head  = empty ? '0 : mem_q[rd_q];
    count = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ir_capture_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 8,
  parameter logic [15:0] MAXPER_RST = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic [1:0]       in_sync_q;
  logic             level, tick;
  logic [3:0]       ien_q, ien_d, sts_q, sts_d, sts_set, sts_clr;
  logic             en_q, en_d, pol_q, pol_d;
  logic [15:0]      maxp_q, maxp_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_acc, rd_acc, fifo_pop, push_ok;
  logic             meter_push, fifo_full, fifo_empty;
  ir_pair_t         meter_pair, fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic [7:0]       fifo_cnt8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) in_sync_q <= 2'b00;
    else             in_sync_q <= {in_sync_q[0], ir_in};
  end
  assign level = in_sync_q[1] ^ pol_q;

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run(en_q), .div(div_q), .tick(tick)
  );

  ir_symbol_meter u_meter (
    .clk(clk), .rst_n(rst_core_n), .run(en_q), .tick(tick), .level(level),
    .max_per(maxp_q), .push(meter_push), .pair(meter_pair)
  );

  ir_pair_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(meter_push), .push_data(meter_pair),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_count), .full(fifo_full),
    .empty(fifo_empty)
  );

  assign fifo_cnt8 = 8'(fifo_count);

  always_comb begin
    wr_acc   = bus_sel && bus_wr;
    rd_acc   = bus_sel && !bus_wr;
    fifo_pop = rd_acc && (bus_addr == A_MARK) && !fifo_empty;
    push_ok  = meter_push && !fifo_full;

    sts_set          = '0;
    sts_set[IB_DATA] = push_ok;
    sts_set[IB_LAST] = push_ok && (meter_pair.period == DUR_MAX);
    sts_set[IB_OVR]  = meter_push && fifo_full;
    sts_set[IB_FULL] = push_ok && !fifo_pop && (fifo_count == CNT_W'(FIFO_DEPTH - 1));
    sts_clr = (wr_acc && bus_addr == A_ICLR) ? bus_wdata[3:0] : 4'h0;
    sts_d   = (sts_q & ~sts_clr) | sts_set;

    ien_d  = (wr_acc && bus_addr == A_IEN)    ? bus_wdata[3:0]       : ien_q;
    en_d   = (wr_acc && bus_addr == A_ENABLE) ? bus_wdata[0]         : en_q;
    pol_d  = (wr_acc && bus_addr == A_POL)    ? bus_wdata[0]         : pol_q;
    maxp_d = (wr_acc && bus_addr == A_MAXPER) ? bus_wdata[15:0]      : maxp_q;
    div_d  = (wr_acc && bus_addr == A_DIV)    ? bus_wdata[DIV_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ien_q  <= '0;
      sts_q  <= '0;
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      maxp_q <= MAXPER_RST;
      div_q  <= DIV_W'(1);
    end else begin
      ien_q  <= ien_d;
      sts_q  <= sts_d;
      en_q   <= en_d;
      pol_q  <= pol_d;
      maxp_q <= maxp_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (bus_addr)
        A_MARK:   bus_rdata = 32'(fifo_head.mark);
        A_PERIOD: bus_rdata = 32'(fifo_head.period);
        A_IEN:    bus_rdata = 32'(ien_q);
        A_ISTS:   bus_rdata = 32'(sts_q);
        A_ENABLE: bus_rdata = 32'(en_q);
        A_MAXPER: bus_rdata = 32'(maxp_q);
        A_DIV:    bus_rdata = 32'(div_q);
        A_POL:    bus_rdata = 32'(pol_q);
        A_RXSTAT: bus_rdata = {16'h0, fifo_cnt8, 5'h0, sts_q[IB_OVR], 2'h0};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/ir_capture_rx_chk.sv
module ir_capture_rx_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        push,
  input logic [15:0] pair_period,
  input logic        full,
  input logic        pop,
  input logic [7:0]  count,
  input logic [3:0]  sts,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata
);
  logic clr_ovr;
  assign clr_ovr = bus_sel && bus_wr && (bus_addr == 8'h58) && bus_wdata[2];

  AST_DISABLED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !push); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 8'(DEPTH)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> count == $past(count)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sts[2] && !clr_ovr |=> sts[2]); // R7
  AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push && !full && pair_period == 16'hFFFF |=> sts[1]); // R8
endmodule

bind ir_capture_rx ir_capture_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(en_q), .push(meter_push),
  .pair_period(meter_pair.period), .full(fifo_full), .pop(fifo_pop),
  .count(fifo_cnt8), .sts(sts_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_ir_capture_rx.sv
module tb_ir_capture_rx;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_capture_rx dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FIAL_MARK %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic drive(input logic lvl, input int n);
    ir_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pair(input string req, input logic [15:0] em, input logic [15:0] ep);
    logic [31:0] d;
    bus_read(8'h44, d); chk({req, " period"}, d, 32'(ep));
    bus_read(8'h40, d); chk({req, " mark"}, d, 32'(em));
  endtask

  task automatic cleanup();
    logic [31:0] d;
    bus_write(8'h50, 0);
    for (int i = 0; i < 10; i++) bus_read(8'h40, d);
    bus_write(8'h58, 32'hF);
    bus_write(8'h48, 0);
    bus_write(8'h68, 0);
    bus_write(8'h64, 1);
    ir_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(8'h6C, d); chk("R11 rxstat", d, 0);
    bus_read(8'h4C, d); chk("R11 intsts", d, 0);
    bus_read(8'h54, d); chk("R11 maxper", d, 32'h5000);
    bus_read(8'h64, d); chk("R1 reset divisor", d, 1);
    bus_read(8'h68, d); chk("R11 polarity", d, 0);
    chk("R11 irq", 32'(irq), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin drive(1, 5); drive(0, 5); end
    drive(0, 10);
    bus_read(8'h6C, d); chk("R5 disabled rxstat", d, 0);
    bus_read(8'h4C, d); chk("R5 disabled intsts", d, 0);
  endtask

  task automatic t_train();
    logic [31:0] d;
    bus_write(8'h54, 40);
    bus_write(8'h50, 1);
    drive(0, 30); drive(1, 5); drive(0, 7); drive(1, 3); drive(0, 6);
    drive(1, 4); drive(0, 100);
    bus_read(8'h6C, d); chk("R10 count 3", d, 32'h0300);
    bus_read(8'h4C, d); chk("R8 data+last", d, 32'h3);
    chk("R9 irq masked off", 32'(irq), 0);
    bus_write(8'h48, 32'h2);
    #1 chk("R9 irq last enabled", 32'(irq), 1);
    read_pair("R3 pair1", 5, 12);
    read_pair("R3 pair2", 3, 9);
    read_pair("R4 last", 4, 16'hFFFF);
    bus_write(8'h58, 32'h2);
    #1 chk("R9 irq after clear", 32'(irq), 0);
    bus_read(8'h4C, d); chk("R8 w1c bit1 only", d, 32'h1);
    cleanup();
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    ir_in = 1'b1;
    bus_write(8'h68, 1);
    bus_write(8'h54, 30);
    bus_write(8'h50, 1);
    drive(1, 10); drive(0, 6); drive(1, 4); drive(0, 2); drive(1, 60);
    bus_read(8'h6C, d); chk("R2 count", d, 32'h0200);
    read_pair("R2 inv pair", 6, 10);
    read_pair("R2 inv last", 2, 16'hFFFF);
    cleanup();
  endtask

  task automatic t_divisor();
    logic [31:0] d;
    bus_write(8'h64, 4);
    bus_write(8'h54, 50);
    bus_write(8'h50, 1);
    drive(0, 40); drive(1, 20); drive(0, 32); drive(1, 8); drive(0, 400);
    bus_read(8'h6C, d); chk("R1 div count", d, 32'h0200);
    read_pair("R1 div pair", 5, 13);
    read_pair("R1 div last", 2, 16'hFFFF);
    cleanup();
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    bus_write(8'h54, 1000);
    bus_write(8'h50, 1);
    drive(0, 10);
    for (int i = 0; i < 10; i++) begin drive(1, 2); drive(0, 2); end
    drive(1, 2); drive(0, 10);
    bus_read(8'h6C, d); chk("R7 full+ovr rxstat", d, 32'h0804);
    bus_read(8'h4C, d); chk("R8 data+ovr+full", d, 32'hD);
    bus_write(8'h58, 32'h4);
    bus_read(8'h4C, d); chk("R7 ovr cleared", d, 32'h9);
    for (int i = 0; i < 8; i++) read_pair("R6 drain", 2, 4);
    bus_read(8'h6C, d); chk("R6 empty after 8", d, 0);
    bus_read(8'h40, d); chk("R6 empty mark 0", d, 0);
    bus_read(8'h44, d); chk("R6 empty period 0", d, 0);
    cleanup();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_train();
    t_polarity();
    t_divisor();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule